// File: doc/BRIEF.md
# Microcontroller Low-Power Mode Controller

This block manages the two low-power modes of a small 8-bit microcontroller. Software writes two control bits: a "doze" bit that stops the processor while timers, serial port and interrupt logic keep running, and a "sleep" bit that turns off the main oscillator. The block gates the CPU clock and the peripheral clock and drives the oscillator enable. It forces the external bus strobes (address-latch enable and program-store enable) to the level each mode calls for. It also decides when the chip may wake. An interrupt-accepted pulse from the interrupt controller ends doze, and it also completes the exit from sleep.

The block runs on an always-on reference clock that stays alive while the main oscillator is off. Only an external interrupt line that is enabled and configured as level-sensitive can start a wake from sleep. While that line is held low, the oscillator is restarted and a counter measures how long the line stays low. When the line is released after the minimum count, the clocks come back and the block waits for the interrupt to be accepted. If the line is released early, the attempt is abandoned and the chip stays asleep.

States: `PM_RUN` (normal), `PM_DOZE` (CPU clock off), `PM_SLEEP` (all clocks and oscillator off), `PM_RESTART` (oscillator on, counting the hold), `PM_HELD` (count met, waiting for release) and `PM_EXIT` (clocks on, waiting for acceptance). Transitions: RUN to SLEEP on a write with the sleep bit set. RUN to DOZE on a write with only the doze bit set. DOZE to RUN on acceptance. SLEEP to RESTART when a qualifying line is seen low. RESTART to SLEEP on early release. RESTART to HELD when the count is met. HELD to EXIT on release. EXIT to RUN on acceptance. Reset leads from every state to RUN.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `mode_bits_o[0]` is the doze bit and `mode_bits_o[1]` the sleep bit. A write in RUN with `ctrl_wr_bits_i` = 2'b01 enters doze. A write with bit 1 set enters sleep, even when bit 0 is also set. A write of 2'b00 changes nothing. Both mode bits are never set together.
- R2: In doze, `cpu_clk_en_o` is 0, `periph_clk_en_o` and `osc_en_o` are 1, and `ale_o` and `psen_o` are both 1.
- R3: An `irq_accept_i` pulse in doze clears the doze bit and returns the block to RUN on the next cycle.
- R4: In sleep before any wake, `cpu_clk_en_o`, `periph_clk_en_o` and `osc_en_o` are 0. While the sleep bit is set, `ale_o` and `psen_o` are 0.
- R5: In sleep, a low line that is disabled (`xint_en_i`=0) or edge-configured (`xint_level_i`=0) does not wake the block. An `irq_accept_i` pulse before the exit stage does not wake it either.
- R6: A line that is enabled, level-configured (`xint_level_i`=1) and low (`xint_n_i`=0) turns `osc_en_o` on within SYNC_STAGES+2 cycles. The CPU and peripheral clocks stay off.
- R7: The line must stay low for at least WAKE_CYCLES (default 1024) cycles. An earlier release turns `osc_en_o` off again and clears the count, so the next attempt needs the full count again.
- R8: Releasing the line after the count turns the CPU and peripheral clocks on while the sleep bit stays set. Then `irq_accept_i` clears the sleep bit and returns the block to RUN.
- R9: In RUN, `ale_o` and `psen_o` follow `core_ale_i` and `core_psen_i`, and all clocks and the oscillator are enabled.
- R10: Reset (`rst_n`=0) from any state puts the block in RUN with both mode bits clear.
- R11: A write while doze or sleep is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| ctrl_wr_en_i | input | 1 | Write strobe for the control bits |
| ctrl_wr_bits_i | input | 2 | Written value: bit 0 doze, bit 1 sleep |
| irq_accept_i | input | 1 | Pulse from the interrupt controller when an interrupt is taken |
| xint_n_i | input | N_XINT | External interrupt pins, active low |
| xint_en_i | input | N_XINT | Per-line interrupt enable |
| xint_level_i | input | N_XINT | Per-line trigger type, 1 = level-sensitive |
| core_ale_i | input | 1 | Address-latch strobe from the core |
| core_psen_i | input | 1 | Program-store strobe from the core |
| mode_bits_o | output | 2 | Current control bits {sleep, doze} |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| periph_clk_en_o | output | 1 | Peripheral clock gate enable |
| osc_en_o | output | 1 | Main oscillator enable |
| ale_o | output | 1 | Address-latch strobe at the pin |
| psen_o | output | 1 | Program-store strobe at the pin |

## Verification
The bench releases the wake line at 600 cycles, twice in a row. A counter that is not cleared on release would add the two holds and wake on the second attempt. It also holds the line well past the minimum before release. A design that woke on the falling edge, or while the line was still held, would show the clocks on too early. The bench drives an edge-configured line, a disabled line, and an accept pulse while asleep. A design that woke on any of these would turn on the oscillator. The bench also writes both bits at once, which must select sleep and not doze. Finally, it writes during doze and asserts reset mid-sleep, where a wrong design would change mode or stay asleep.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [2:0] {
        PM_RUN     = 3'd0,
        PM_DOZE    = 3'd1,
        PM_SLEEP   = 3'd2,
        PM_RESTART = 3'd3,
        PM_HELD    = 3'd4,
        PM_EXIT    = 3'd5
    } pm_state_e;

    localparam int unsigned DOZE_BIT  = 0;
    localparam int unsigned SLEEP_BIT = 1;

endpackage

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode (
    input  logic       wr_en_i,
    input  logic [1:0] wr_bits_i,
    input  logic       accept_wr_i,
    output logic       go_doze_o,
    output logic       go_sleep_o
);
    import pwr_pkg::*;

    logic wr_ok;

    always_comb begin
        wr_ok      = wr_en_i & accept_wr_i;
        // sleep takes precedence when both bits are set
        go_sleep_o = wr_ok & wr_bits_i[SLEEP_BIT];
        go_doze_o  = wr_ok & wr_bits_i[DOZE_BIT] & ~wr_bits_i[SLEEP_BIT];
    end
endmodule

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
    parameter int unsigned N_XINT      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_XINT-1:0] pin_n_i,
    input  logic [N_XINT-1:0] en_i,
    input  logic [N_XINT-1:0] level_i,
    output logic              wake_o
);
    logic [N_XINT-1:0] line_qual;

    for (genvar g = 0; g < N_XINT; g++) begin : g_line
        logic [SYNC_STAGES-1:0] shreg;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shreg <= '1;
            end else begin
                shreg <= {shreg[SYNC_STAGES-2:0], pin_n_i[g]};
            end
        end

        // only enabled, level-configured lines held low can wake
        always_comb line_qual[g] = ~shreg[SYNC_STAGES-1] & en_i[g] & level_i[g];
    end

    always_comb wake_o = |line_qual;
endmodule

// File: rtl/pwr_restart_cnt.sv
module pwr_restart_cnt #(
    parameter int unsigned WAKE_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_i,
    output logic done_o
);
    localparam int unsigned CW = (WAKE_CYCLES > 2) ? $clog2(WAKE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (count_i) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    always_comb done_o = (cnt == LAST);
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_doze_i,
    input  logic       go_sleep_i,
    input  logic       irq_accept_i,
    input  logic       wake_i,
    input  logic       cnt_done_i,
    input  logic       core_ale_i,
    input  logic       core_psen_i,
    output logic       in_run_o,
    output logic       cnt_run_o,
    output logic [1:0] mode_bits_o,
    output logic       cpu_clk_en_o,
    output logic       periph_clk_en_o,
    output logic       osc_en_o,
    output logic       ale_o,
    output logic       psen_o
);
    import pwr_pkg::*;

    pm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PM_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN: begin
                if (go_sleep_i)     state_d = PM_SLEEP;
                else if (go_doze_i) state_d = PM_DOZE;
            end
            PM_DOZE: begin
                if (irq_accept_i) state_d = PM_RUN;
            end
            PM_SLEEP: begin
                if (wake_i) state_d = PM_RESTART;
            end
            PM_RESTART: begin
                if (!wake_i)         state_d = PM_SLEEP;
                else if (cnt_done_i) state_d = PM_HELD;
            end
            PM_HELD: begin
                if (!wake_i) state_d = PM_EXIT;
            end
            PM_EXIT: begin
                if (irq_accept_i) state_d = PM_RUN;
            end
            default: state_d = PM_RUN;
        endcase
    end

    always_comb begin
        in_run_o        = 1'b0;
        cnt_run_o       = 1'b0;
        mode_bits_o     = 2'b00;
        cpu_clk_en_o    = 1'b1;
        periph_clk_en_o = 1'b1;
        osc_en_o        = 1'b1;
        ale_o           = core_ale_i;
        psen_o          = core_psen_i;
        unique case (state_q)
            PM_RUN: begin
                in_run_o = 1'b1;
            end
            PM_DOZE: begin
                mode_bits_o[DOZE_BIT] = 1'b1;
                cpu_clk_en_o          = 1'b0;
                ale_o                 = 1'b1;
                psen_o                = 1'b1;
            end
            PM_SLEEP: begin
                mode_bits_o[SLEEP_BIT] = 1'b1;
                cpu_clk_en_o           = 1'b0;
                periph_clk_en_o        = 1'b0;
                osc_en_o               = 1'b0;
                ale_o                  = 1'b0;
                psen_o                 = 1'b0;
            end
            PM_RESTART, PM_HELD: begin
                mode_bits_o[SLEEP_BIT] = 1'b1;
                cnt_run_o              = (state_q == PM_RESTART) && wake_i;
                cpu_clk_en_o           = 1'b0;
                periph_clk_en_o        = 1'b0;
                ale_o                  = 1'b0;
                psen_o                 = 1'b0;
            end
            PM_EXIT: begin
                mode_bits_o[SLEEP_BIT] = 1'b1;
                ale_o                  = 1'b0;
                psen_o                 = 1'b0;
            end
            default: begin
                in_run_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
    parameter int unsigned N_XINT      = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned WAKE_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_en_i,
    input  logic [1:0]        ctrl_wr_bits_i,
    input  logic              irq_accept_i,
    input  logic [N_XINT-1:0] xint_n_i,
    input  logic [N_XINT-1:0] xint_en_i,
    input  logic [N_XINT-1:0] xint_level_i,
    input  logic              core_ale_i,
    input  logic              core_psen_i,
    output logic [1:0]        mode_bits_o,
    output logic              cpu_clk_en_o,
    output logic              periph_clk_en_o,
    output logic              osc_en_o,
    output logic              ale_o,
    output logic              psen_o
);
    logic in_run;
    logic go_doze;
    logic go_sleep;
    logic wake;
    logic cnt_run;
    logic cnt_done;

    pwr_cmd_decode u_dec (
        .wr_en_i     (ctrl_wr_en_i),
        .wr_bits_i   (ctrl_wr_bits_i),
        .accept_wr_i (in_run),
        .go_doze_o   (go_doze),
        .go_sleep_o  (go_sleep)
    );

    pwr_wake_sync #(
        .N_XINT      (N_XINT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n_i (xint_n_i),
        .en_i    (xint_en_i),
        .level_i (xint_level_i),
        .wake_o  (wake)
    );

    pwr_restart_cnt #(
        .WAKE_CYCLES (WAKE_CYCLES)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_i (cnt_run),
        .done_o  (cnt_done)
    );

    pwr_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .go_doze_i       (go_doze),
        .go_sleep_i      (go_sleep),
        .irq_accept_i    (irq_accept_i),
        .wake_i          (wake),
        .cnt_done_i      (cnt_done),
        .core_ale_i      (core_ale_i),
        .core_psen_i     (core_psen_i),
        .in_run_o        (in_run),
        .cnt_run_o       (cnt_run),
        .mode_bits_o     (mode_bits_o),
        .cpu_clk_en_o    (cpu_clk_en_o),
        .periph_clk_en_o (periph_clk_en_o),
        .osc_en_o        (osc_en_o),
        .ale_o           (ale_o),
        .psen_o          (psen_o)
    );
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
    parameter int unsigned WAKE_CYCLES = 1024
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_wr_en_i,
    input logic       irq_accept_i,
    input logic [1:0] mode_bits_o,
    input logic       cpu_clk_en_o,
    input logic       periph_clk_en_o,
    input logic       osc_en_o,
    input logic       ale_o,
    input logic       psen_o
);
    logic [31:0] hold_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (mode_bits_o[1] && osc_en_o && !cpu_clk_en_o) begin
            hold_cnt <= hold_cnt + 1;
        end else begin
            hold_cnt <= '0;
        end
    end

    AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_bits_o[0] && mode_bits_o[1])); // R1

    AST_DOZE_GATING: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bits_o[0] |-> (!cpu_clk_en_o && periph_clk_en_o && osc_en_o && ale_o && psen_o)); // R2

    AST_DOZE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits_o[0] && irq_accept_i) |=> (mode_bits_o == 2'b00)); // R3

    AST_SLEEP_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bits_o[1] |-> (!ale_o && !psen_o)); // R4

    AST_SLEEP_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits_o[1] && !osc_en_o) |-> (!cpu_clk_en_o && !periph_clk_en_o)); // R4

    AST_EARLY_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits_o[1] && !cpu_clk_en_o && irq_accept_i) |=> mode_bits_o[1]); // R5

    AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits_o[1] && $rose(cpu_clk_en_o)) |-> (hold_cnt >= WAKE_CYCLES)); // R7

    AST_EXIT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits_o[1] && cpu_clk_en_o && irq_accept_i) |=> (mode_bits_o == 2'b00)); // R8

    AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits_o[0] && ctrl_wr_en_i && !irq_accept_i) |=> mode_bits_o[0]); // R11
endmodule

bind pwr_mode_ctrl pwr_mode_chk #(
    .WAKE_CYCLES (WAKE_CYCLES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ctrl_wr_en_i    (ctrl_wr_en_i),
    .irq_accept_i    (irq_accept_i),
    .mode_bits_o     (mode_bits_o),
    .cpu_clk_en_o    (cpu_clk_en_o),
    .periph_clk_en_o (periph_clk_en_o),
    .osc_en_o        (osc_en_o),
    .ale_o           (ale_o),
    .psen_o          (psen_o)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;

    localparam int unsigned N_XINT = 2;

    // {sleep, doze, cpu, periph, osc, ale, psen}; core drives ale=0, psen=1
    localparam logic [6:0] E_RUN   = 7'b00_111_01;
    localparam logic [6:0] E_DOZE  = 7'b01_011_11;
    localparam logic [6:0] E_SLEEP = 7'b10_000_00;
    localparam logic [6:0] E_OSC   = 7'b10_001_00;
    localparam logic [6:0] E_EXIT  = 7'b10_111_00;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_bits = 2'b00;
    logic              accept = 1'b0;
    logic [N_XINT-1:0] pin_n = '1;
    logic [N_XINT-1:0] en = 2'b11;
    logic [N_XINT-1:0] level = 2'b01;
    logic [1:0]        mode_bits;
    logic              cpu_en, per_en, osc_en, ale, psen;

    typedef struct {
        string      req;
        logic [6:0] exp;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .ctrl_wr_en_i    (wr_en),
        .ctrl_wr_bits_i  (wr_bits),
        .irq_accept_i    (accept),
        .xint_n_i        (pin_n),
        .xint_en_i       (en),
        .xint_level_i    (level),
        .core_ale_i      (1'b0),
        .core_psen_i     (1'b1),
        .mode_bits_o     (mode_bits),
        .cpu_clk_en_o    (cpu_en),
        .periph_clk_en_o (per_en),
        .osc_en_o        (osc_en),
        .ale_o           (ale),
        .psen_o          (psen)
    );

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [6:0] act;
            it  = q.pop_front();
            act = {mode_bits, cpu_en, per_en, osc_en, ale, psen};
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual %b expected %b", it.req, act, it.exp);
            end
        end
    end

    task automatic expect_out(input string req, input logic [6:0] exp);
        item_t it;
        it.req = req;
        it.exp = exp;
        q.push_back(it);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_write(input logic [1:0] b);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_bits = b;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_bits = 2'b00;
    endtask

    task automatic do_accept();
        @(posedge clk); #1;
        accept = 1'b1;
        @(posedge clk); #1;
        accept = 1'b0;
    endtask

    task automatic hold_line(input int idx, input int n);
        pin_n[idx] = 1'b0;
        cycles(n);
        pin_n[idx] = 1'b1;
    endtask

    initial begin
        cycles(3);
        expect_out("R10 reset state", E_RUN);
        rst_n = 1'b1;
        cycles(2);
        expect_out("R9 run strobes and clocks", E_RUN);

        do_write(2'b00);
        cycles(1);
        expect_out("R1 write of zero", E_RUN);

        do_write(2'b01);
        expect_out("R1 R2 enter doze", E_DOZE);
        do_write(2'b10);
        cycles(1);
        expect_out("R11 write in doze ignored", E_DOZE);
        do_accept();
        expect_out("R3 doze exit on accept", E_RUN);

        do_write(2'b11);
        expect_out("R1 R4 both bits select sleep", E_SLEEP);
        hold_line(1, 50);
        cycles(5);
        expect_out("R5 edge-configured line ignored", E_SLEEP);
        en[0] = 1'b0;
        hold_line(0, 50);
        cycles(5);
        expect_out("R5 disabled line ignored", E_SLEEP);
        en[0] = 1'b1;
        do_accept();
        cycles(2);
        expect_out("R5 accept in sleep ignored", E_SLEEP);
        do_write(2'b01);
        cycles(1);
        expect_out("R11 write in sleep ignored", E_SLEEP);

        pin_n[0] = 1'b0;
        cycles(5);
        expect_out("R6 oscillator restart", E_OSC);
        cycles(595);
        pin_n[0] = 1'b1;
        cycles(5);
        expect_out("R7 early release back to sleep", E_SLEEP);
        hold_line(0, 600);
        cycles(5);
        expect_out("R7 count cleared after release", E_SLEEP);

        pin_n[0] = 1'b0;
        cycles(1100);
        expect_out("R7 held past count, clocks off", E_OSC);
        pin_n[0] = 1'b1;
        cycles(5);
        expect_out("R8 exit stage after release", E_EXIT);
        cycles(5);
        expect_out("R8 sleep bit kept until accept", E_EXIT);
        do_accept();
        expect_out("R8 R9 accept returns to run", E_RUN);

        do_write(2'b10);
        expect_out("R1 sleep bit alone", E_SLEEP);
        pin_n[0] = 1'b0;
        cycles(10);
        rst_n = 1'b0;
        pin_n[0] = 1'b1;
        #0.5;
        expect_out("R10 reset leaves restart", E_RUN);
        cycles(2);
        rst_n = 1'b1;
        do_write(2'b01);
        @(posedge clk); #0.5;
        rst_n = 1'b0;
        #0.5;
        expect_out("R10 reset leaves doze", E_RUN);
        cycles(2);
        rst_n = 1'b1;
        cycles(3);
        expect_out("R10 run after reset", E_RUN);
        cycles(2);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            #(200000 * 5);
        join_any
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule